// File: doc/BRIEF.md
# Audio Clock Frame Meter

This block lives in the system clock domain and measures a free-running, unrelated audio clock against a periodic frame strobe. For every frame interval it reports how many whole audio cycles fit between two frame strobes. The interval is anchored not on the strobe itself but on the first audio rising edge at or after it. Alongside that whole-cycle count it reports how many system clocks separated each strobe from its anchoring audio edge.

A second, independent measurement counts system clocks across a programmable number N of audio periods and restarts by itself. Software divides that figure by N to get system clocks per audio cycle. It then scales the difference between the previous and current phase counts by that figure to add a fractional part to the whole-cycle count. Software uses the result to steer a sample-rate converter.

Both raw inputs pass through multi-flop synchronizers before their rising edges are detected. Every counter saturates rather than wraps. A sticky flag records that some counter ran out of range.

Top module: `audio_clk_meter`

## Requirements
- R1: After reset all result outputs are zero, both strobes are low and the overflow flag is clear.
- R2: After reset, the first frame strobe that finds an audio edge only arms the meter. The frame strobe `frm_vld_o` first rises at the second anchoring audio edge.
- R3: `frm_cnt_o` equals the number of audio rising edges after one anchoring edge up to and including the next. An anchoring edge is the first audio rising edge in the same system cycle as a frame strobe rising edge or later.
- R4: `ph_cur_o` equals the number of system cycles from the frame strobe rising edge to its anchoring audio edge, and is 0 when both rise in the same cycle.
- R5: `ph_prev_o` carries the phase count of the interval's opening anchor. It is updated in the same cycle as `frm_cnt_o` and `ph_cur_o`.
- R6: `frm_vld_o` is high for exactly one cycle per result, and the three frame outputs do not change while it is low.
- R7: `per_cnt_o` equals the number of system cycles between an audio edge and the edge N periods later, where N is `per_cfg_i` and a value of 0 acts as 1. The measurement restarts at each such closing edge, flags each result with a one-cycle `per_vld_o`, and holds `per_cnt_o` between strobes.
- R8: Every count saturates at the all-ones value of its output width instead of wrapping.
- R9: `ovf_o` sets when any counter would pass its all-ones value, and stays set until reset.
- R10: A new frame strobe arriving before the pending anchoring edge replaces the earlier one, so the phase count is measured from the later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| aud_clk_i | input | 1 | Raw audio clock, asynchronous |
| frm_pulse_i | input | 1 | Raw frame strobe, asynchronous |
| per_cfg_i | input | CFG_W | Number of audio periods per period measurement (0 acts as 1) |
| frm_cnt_o | output | CNT_W | Whole audio cycles in the last frame interval |
| ph_cur_o | output | PH_W | Phase count at the interval's closing anchor |
| ph_prev_o | output | PH_W | Phase count at the interval's opening anchor |
| frm_vld_o | output | 1 | One-cycle strobe for a new frame result |
| per_cnt_o | output | PER_W | System cycles across N audio periods |
| per_vld_o | output | 1 | One-cycle strobe for a new period result |
| ovf_o | output | 1 | Sticky counter overflow flag |

## Verification
The bench builds the meter with 6-bit frame and phase counts, an 8-bit period count and a 4-bit period setting. It drives both raw inputs on the falling clock edge, so both synchronizer paths add the same delay and every expected value is an exact cycle difference. The narrow widths bring saturation of all three counters, and the overflow flag, within a few hundred cycles. This makes it possible to drive a stalled audio clock, an over-long frame and an over-long period measurement next to the ordinary cases of strobe replacement, a strobe and an audio edge in the same cycle, and a period setting of zero.

// File: rtl/acm_pkg.sv
package acm_pkg;
   localparam int unsigned LANE_FRM  = 0;
   localparam int unsigned LANE_AUD  = 1;
   localparam int unsigned NUM_LANES = 2;
   localparam int unsigned MIN_SYNC  = 2;
endpackage

// File: rtl/acm_sync.sv
module acm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_raw_i,
   output logic rise_o
);
   localparam int unsigned DEPTH = STAGES + 1;

   logic [DEPTH-1:0] pipe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[DEPTH-2:0], d_raw_i};
   end

   assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/acm_frame_ctr.sv
module acm_frame_ctr #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PH_W  = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             frm_rise_i,
   input  logic             aud_rise_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [PH_W-1:0]  ph_cur_o,
   output logic [PH_W-1:0]  ph_prev_o,
   output logic             vld_o,
   output logic             armed_o,
   output logic             ovf_ev_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [PH_W-1:0]  PH_MAX  = {PH_W{1'b1}};

   logic             pend_q, armed_q, vld_q;
   logic [PH_W-1:0]  ph_ctr_q, ph_start_q, ph_cur_q, ph_prev_q;
   logic [CNT_W-1:0] cyc_q, cnt_q;
   logic             anchor;
   logic [PH_W-1:0]  ph_now;
   logic [CNT_W-1:0] cyc_close;
   logic             ph_ovf, cyc_ovf;

   // an audio edge anchors when a strobe is pending or arrives with it
   assign anchor    = aud_rise_i & (pend_q | frm_rise_i);
   assign ph_now    = frm_rise_i ? '0 : ph_ctr_q;
   assign cyc_close = (cyc_q == CNT_MAX) ? CNT_MAX : cyc_q + CNT_W'(1);

   assign ph_ovf  = pend_q & ~frm_rise_i & ~aud_rise_i & (ph_ctr_q == PH_MAX);
   assign cyc_ovf = armed_q & aud_rise_i & (cyc_q == CNT_MAX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q     <= 1'b0;
         armed_q    <= 1'b0;
         vld_q      <= 1'b0;
         ph_ctr_q   <= '0;
         ph_start_q <= '0;
         ph_cur_q   <= '0;
         ph_prev_q  <= '0;
         cyc_q      <= '0;
         cnt_q      <= '0;
      end else begin
         vld_q <= 1'b0;
         if (anchor) begin
            pend_q     <= 1'b0;
            armed_q    <= 1'b1;
            ph_start_q <= ph_now;
            cyc_q      <= '0;
            if (armed_q) begin
               cnt_q     <= cyc_close;
               ph_cur_q  <= ph_now;
               ph_prev_q <= ph_start_q;
               vld_q     <= 1'b1;
            end
         end else begin
            if (frm_rise_i) begin
               pend_q   <= 1'b1;
               ph_ctr_q <= PH_W'(1);
            end else if (pend_q && ph_ctr_q != PH_MAX) begin
               ph_ctr_q <= ph_ctr_q + PH_W'(1);
            end
            if (armed_q && aud_rise_i && cyc_q != CNT_MAX)
               cyc_q <= cyc_q + CNT_W'(1);
         end
      end
   end

   assign cnt_o     = cnt_q;
   assign ph_cur_o  = ph_cur_q;
   assign ph_prev_o = ph_prev_q;
   assign vld_o     = vld_q;
   assign armed_o   = armed_q;
   assign ovf_ev_o  = ph_ovf | cyc_ovf;
endmodule

// File: rtl/acm_period_ctr.sv
module acm_period_ctr #(
   parameter int unsigned PER_W = 20,
   parameter int unsigned CFG_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             aud_rise_i,
   input  logic [CFG_W-1:0] cfg_i,
   output logic [PER_W-1:0] per_o,
   output logic             vld_o,
   output logic             ovf_ev_o
);
   localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};
   localparam int unsigned      EW      = CFG_W + 1;

   logic             run_q, vld_q;
   logic [PER_W-1:0] sys_q, per_q, sys_inc;
   logic [CFG_W-1:0] edges_q;
   logic             last_edge, closing;

   // a setting of 0 closes at every edge, same as 1
   assign last_edge = (EW'(edges_q) + EW'(1)) >= EW'(cfg_i);
   assign closing   = run_q & aud_rise_i & last_edge;
   assign sys_inc   = (sys_q == PER_MAX) ? PER_MAX : sys_q + PER_W'(1);
   assign ovf_ev_o  = run_q & ~closing & (sys_q == PER_MAX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= 1'b0;
         vld_q   <= 1'b0;
         sys_q   <= '0;
         per_q   <= '0;
         edges_q <= '0;
      end else begin
         vld_q <= 1'b0;
         if (aud_rise_i) begin
            if (!run_q || last_edge) begin
               run_q   <= 1'b1;
               sys_q   <= PER_W'(1);
               edges_q <= '0;
               if (run_q) begin
                  per_q <= sys_q;
                  vld_q <= 1'b1;
               end
            end else begin
               edges_q <= edges_q + CFG_W'(1);
               sys_q   <= sys_inc;
            end
         end else if (run_q) begin
            sys_q <= sys_inc;
         end
      end
   end

   assign per_o = per_q;
   assign vld_o = vld_q;
endmodule

// File: rtl/audio_clk_meter.sv
module audio_clk_meter #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned PH_W        = 12,
   parameter int unsigned PER_W       = 20,
   parameter int unsigned CFG_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             aud_clk_i,
   input  logic             frm_pulse_i,
   input  logic [CFG_W-1:0] per_cfg_i,
   output logic [CNT_W-1:0] frm_cnt_o,
   output logic [PH_W-1:0]  ph_cur_o,
   output logic [PH_W-1:0]  ph_prev_o,
   output logic             frm_vld_o,
   output logic [PER_W-1:0] per_cnt_o,
   output logic             per_vld_o,
   output logic             ovf_o
);
   import acm_pkg::*;

   if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 2 || PH_W < 2 || PER_W < 2 || CFG_W < 1) begin : g_bad_width
      $error("counter widths too small");
   end

   logic [NUM_LANES-1:0] raw_vec, rise_vec;
   logic                 frm_armed;
   logic                 frm_ovf_ev, per_ovf_ev;
   logic                 ovf_q;

   assign raw_vec[LANE_FRM] = frm_pulse_i;
   assign raw_vec[LANE_AUD] = aud_clk_i;

   for (genvar li = 0; li < NUM_LANES; li++) begin : g_lane
      acm_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .d_raw_i (raw_vec[li]),
         .rise_o  (rise_vec[li])
      );
   end

   acm_frame_ctr #(.CNT_W(CNT_W), .PH_W(PH_W)) u_frame (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frm_rise_i (rise_vec[LANE_FRM]),
      .aud_rise_i (rise_vec[LANE_AUD]),
      .cnt_o      (frm_cnt_o),
      .ph_cur_o   (ph_cur_o),
      .ph_prev_o  (ph_prev_o),
      .vld_o      (frm_vld_o),
      .armed_o    (frm_armed),
      .ovf_ev_o   (frm_ovf_ev)
   );

   acm_period_ctr #(.PER_W(PER_W), .CFG_W(CFG_W)) u_period (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .aud_rise_i (rise_vec[LANE_AUD]),
      .cfg_i      (per_cfg_i),
      .per_o      (per_cnt_o),
      .vld_o      (per_vld_o),
      .ovf_ev_o   (per_ovf_ev)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ovf_q <= 1'b0;
      else         ovf_q <= ovf_q | frm_ovf_ev | per_ovf_ev;
   end

   assign ovf_o = ovf_q;
endmodule

// File: rtl/acm_checker.sv
module acm_checker #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PH_W  = 12,
   parameter int unsigned PER_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frm_vld,
   input logic [CNT_W-1:0] frm_cnt,
   input logic [PH_W-1:0]  ph_cur,
   input logic [PH_W-1:0]  ph_prev,
   input logic             per_vld,
   input logic [PER_W-1:0] per_cnt,
   input logic             ovf,
   input logic             armed
);
   p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |=> !frm_vld);

   p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_vld |-> ($stable(frm_cnt) && $stable(ph_cur) && $stable(ph_prev)));

   p_period_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !per_vld |-> $stable(per_cnt));

   p_per_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      per_vld |=> !per_vld);

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   p_armed_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |-> $past(armed));

   p_cnt_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |-> (frm_cnt != '0));
endmodule

bind audio_clk_meter acm_checker #(
   .CNT_W(CNT_W), .PH_W(PH_W), .PER_W(PER_W)
) u_chk (
   .clk     (clk_i),
   .rst_n   (rst_ni),
   .frm_vld (frm_vld_o),
   .frm_cnt (frm_cnt_o),
   .ph_cur  (ph_cur_o),
   .ph_prev (ph_prev_o),
   .per_vld (per_vld_o),
   .per_cnt (per_cnt_o),
   .ovf     (ovf_o),
   .armed   (frm_armed)
);

// File: tb/audio_clk_meter_tb_top.sv
`timescale 1ns/1ps
module audio_clk_meter_tb_top;
   localparam int unsigned CNT_W = 6;
   localparam int unsigned PH_W  = 6;
   localparam int unsigned PER_W = 8;
   localparam int unsigned CFG_W = 4;
   localparam int CNT_MAX = (1 << CNT_W) - 1;
   localparam int PH_MAX  = (1 << PH_W) - 1;
   localparam int PER_MAX = (1 << PER_W) - 1;

   typedef struct {
      int cnt;
      int cur;
      int prev;
   } frm_item_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             aud_raw = 1'b0;
   logic             frm_raw = 1'b0;
   logic [CFG_W-1:0] cfg = '0;
   logic [CNT_W-1:0] frm_cnt;
   logic [PH_W-1:0]  ph_cur, ph_prev;
   logic             frm_vld, per_vld, ovf;
   logic [PER_W-1:0] per_cnt;

   int checks = 0;
   int failures = 0;
   bit mon_en = 1'b0;
   int exp_per = 0;
   int per_seen = 0;
   int pls[$];
   frm_item_t exp_q[$];

   always #2.5 clk = ~clk;

   audio_clk_meter #(
      .CNT_W(CNT_W), .PH_W(PH_W), .PER_W(PER_W), .CFG_W(CFG_W), .SYNC_STAGES(2)
   ) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .aud_clk_i   (aud_raw),
      .frm_pulse_i (frm_raw),
      .per_cfg_i   (cfg),
      .frm_cnt_o   (frm_cnt),
      .ph_cur_o    (ph_cur),
      .ph_prev_o   (ph_prev),
      .frm_vld_o   (frm_vld),
      .per_cnt_o   (per_cnt),
      .per_vld_o   (per_vld),
      .ovf_o       (ovf)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int min_i(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // monitor: pops the scoreboard on every frame result, checks period results
   always @(negedge clk) begin
      if (mon_en && frm_vld) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected frame result cnt", int'(frm_cnt), -1);
         end else begin
            frm_item_t it;
            it = exp_q.pop_front();
            chk(int'(frm_cnt) == it.cnt, "R3", "frame count", int'(frm_cnt), it.cnt);
            chk(int'(ph_cur) == it.cur, "R4", "current phase", int'(ph_cur), it.cur);
            chk(int'(ph_prev) == it.prev, "R5", "previous phase", int'(ph_prev), it.prev);
         end
      end
      if (mon_en && per_vld) begin
         per_seen++;
         chk(int'(per_cnt) == exp_per, "R7", "period count", int'(per_cnt), exp_per);
      end
   end

   task automatic do_reset();
      rst_n   = 1'b0;
      aud_raw = 1'b0;
      frm_raw = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(frm_cnt == '0 && ph_cur == '0 && ph_prev == '0, "R1", "frame outputs after reset",
          int'(frm_cnt) + int'(ph_cur) + int'(ph_prev), 0);
      chk(per_cnt == '0, "R1", "period output after reset", int'(per_cnt), 0);
      chk(!frm_vld && !per_vld, "R1", "strobes after reset", int'(frm_vld) + int'(per_vld), 0);
      chk(!ovf, "R1", "overflow after reset (R9 cleared)", int'(ovf), 0);
   endtask

   // driver: computes expected items into the scoreboard, then drives the raw pins
   task automatic run_scen(input string name, input int p, input int a0, input int stop,
                           input int ncfg, input int ncyc, input bit exp_ovf);
      int anc[$];
      int src[$];
      int edges;
      int n_eff;
      edges = 0;
      for (int c = a0; c < ncyc && c < stop; c += p) edges++;
      n_eff = (ncfg == 0) ? 1 : ncfg;
      exp_per = min_i(n_eff * p, PER_MAX);
      per_seen = 0;
      for (int i = 0; i < pls.size(); i++) begin
         int a;
         a = -1;
         for (int c = pls[i]; c < ncyc && c < stop; c++)
            if (c >= a0 && ((c - a0) % p) == 0) begin a = c; break; end
         if (a < 0) continue;
         if (i + 1 < pls.size() && pls[i+1] <= a) continue; // R10 later strobe wins
         anc.push_back(a);
         src.push_back(pls[i]);
      end
      for (int k = 1; k < anc.size(); k++) begin
         frm_item_t it;
         it.cnt  = min_i((anc[k] - anc[k-1]) / p, CNT_MAX);
         it.cur  = min_i(anc[k] - src[k], PH_MAX);
         it.prev = min_i(anc[k-1] - src[k-1], PH_MAX);
         exp_q.push_back(it);
      end
      cfg = CFG_W'(ncfg);
      mon_en = 1'b1;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         aud_raw = (c >= a0 && c < stop && ((c - a0) % p) < p / 2);
         frm_raw = 1'b0;
         foreach (pls[j]) if (pls[j] == c) frm_raw = 1'b1;
      end
      @(negedge clk);
      aud_raw = 1'b0;
      frm_raw = 1'b0;
      repeat (8) @(negedge clk);
      mon_en = 1'b0;
      chk(exp_q.size() == 0, "R3", {name, " missing frame results"}, exp_q.size(), 0);
      exp_q.delete();
      chk(per_seen == ((edges > 0) ? (edges - 1) / n_eff : 0), "R7",
          {name, " period result count"}, per_seen, (edges - 1) / n_eff);
      chk(ovf == exp_ovf, "R9", {name, " overflow flag"}, int'(ovf), int'(exp_ovf));
   endtask

   initial begin
      #(5.0 * 150000);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();

      // R3 R4 R5: varied strobe positions against a steady audio clock
      pls = '{10, 45, 100, 130};
      run_scen("steady", 8, 3, 100000, 4, 170, 1'b0);
      do_reset();

      // R10 strobe replacement, R4 same-cycle anchor, R7 setting 0 acts as 1
      pls = '{20, 31, 33, 65};
      run_scen("replace", 10, 5, 100000, 0, 100, 1'b0);
      do_reset();

      // R2 single strobe only arms; R8 period saturates
      pls = '{5};
      run_scen("per_sat", 20, 2, 100000, 15, 700, 1'b1);
      chk(int'(per_cnt) == PER_MAX, "R8", "period saturated value", int'(per_cnt), PER_MAX);
      chk(frm_cnt == '0, "R2", "no frame result after one strobe", int'(frm_cnt), 0);
      do_reset();

      // R8 frame count saturates
      pls = '{4, 200};
      run_scen("cnt_sat", 2, 1, 100000, 8, 230, 1'b1);
      chk(int'(frm_cnt) == CNT_MAX, "R8", "frame count held at max", int'(frm_cnt), CNT_MAX);
      do_reset();

      // R8 R9 stalled audio: phase counter runs out; R6 outputs hold
      pls = '{10, 30, 36};
      run_scen("stall", 8, 1, 40, 2, 140, 1'b1);
      chk(int'(ph_cur) == 3 && int'(frm_cnt) == 2, "R6", "frame outputs held after stall",
          int'(ph_cur), 3);
      repeat (20) @(negedge clk);
      chk(ovf == 1'b1, "R9", "overflow stays set", int'(ovf), 1);
      do_reset();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule